// File: doc/BRIEF.md
# Single-Skip Branch Annulment Controller

This control unit serves a scalar, in-order pipeline of eight stages. It watches the decode stage for conditional forward branches whose target lies exactly one instruction beyond their fall-through address. The predictor's confidence can mark a branch as strongly taken. If it does not, the unit accepts the branch as a branch-over and asks the front end to fetch straight through the skipped instruction. The front end does this as if the branch were not taken. Only one branch-over may be in flight at a time. Every other branch falls back to the ordinary predicted path.

Each pipeline slot carries a valid bit, a branch tag, a predicted-direction bit, a branch-over tag, a shadow tag and an annul bit. Every branch resolves as it leaves the eighth stage. A branch-over that resolves taken has its single shadow instruction marked as a bubble, and younger work continues. If the shadow has not yet entered the pipeline, or has already reached the first stage that changes state, the unit requests a full flush instead. An ordinary branch that was mispredicted raises a full flush with a redirect. A pipeline stall freezes all tracking. Three counters report accepted branch-overs, annulled shadows and full flushes.

Top module: `sfb_annul_ctl`

## Requirements
- R1: After reset every slot is empty: `annul_o` is 0, `flush_o` is 0 and all three counters read 0.
- R2: A decode-stage instruction is accepted as a branch-over when all of the following hold: it is valid, conditional, short-forward and not strongly taken, no other branch-over is in flight, and the pipeline is not stalled. Acceptance shows as `bo_take_o`=1 in that cycle, and `cnt_bo_o` increments on the next cycle.
- R3: An eligible branch that arrives while a branch-over is in flight gets `bo_take_o`=0 and is handled as an ordinary branch. If such a branch mispredicts at resolve, it raises `flush_o`.
- R4: An eligible branch with `dec_strong_i`=1 gets `bo_take_o`=0. If it resolves in its predicted direction, it causes neither a flush nor an annul.
- R5: A branch-over resolves taken when its shadow is in a stage numbered below COMMIT. In that case the shadow's annul bit is set and moves with it, so `annul_o` bit 7 (stage 8) reads 1 in the cycle after the resolve. No flush is raised, younger instructions are not annulled, and `cnt_ann_o` increments.
- R6: A branch-over resolves not taken: no annul and no flush occur. Its tracking is released in the same cycle, so an eligible branch in decode in that cycle is accepted.
- R7: An ordinary branch whose outcome differs from `dec_pred_i` raises `flush_o` in its resolve cycle. It drives `redir_tgt_o` to the actual outcome (1 = target, 0 = fall-through), empties every slot and increments `cnt_flush_o`.
- R8: A branch-over resolves taken while its shadow has not yet entered the pipeline. The unit raises `flush_o` with `redir_tgt_o`=1.
- R9: While `stall_i`=1, nothing resolves, nothing enters, and `annul_o` and the counters hold their values.
- R10: A flush caused by an older branch discards any pending branch-over, so an eligible branch in the very next cycle is accepted.
- R11: An annulled instruction that is itself a branch is not resolved: its outcome raises no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Pipeline hold; no slot advances |
| dec_valid_i | input | 1 | An instruction enters stage 1 at this edge |
| dec_branch_i | input | 1 | That instruction is a conditional branch |
| dec_short_i | input | 1 | Its target skips exactly one instruction |
| dec_strong_i | input | 1 | Predictor rates it strongly taken |
| dec_pred_i | input | 1 | Ordinary predicted direction (1 = taken) |
| res_taken_i | input | 1 | Actual outcome of the branch in stage 8 |
| bo_take_o | output | 1 | Branch in decode accepted as branch-over; fetch through |
| annul_o | output | NST | Per-stage bubble control, bit i = stage i+1 |
| flush_o | output | 1 | Full flush of younger work and fetch redirect |
| redir_tgt_o | output | 1 | Redirect toward target (1) or fall-through (0) |
| cnt_bo_o | output | CW | Accepted branch-overs |
| cnt_ann_o | output | CW | Annulled shadow instructions |
| cnt_flush_o | output | CW | Full flushes |

## Verification
An instruction offered in decode during cycle n occupies stage 8 in cycle n+8, given no stall. Its resolve outcome must be driven in that cycle, and `flush_o` and `redir_tgt_o` are due there combinationally. A shadow annulled at that resolve shows in `annul_o` bit 7 in cycle n+9. `bo_take_o` is due in cycle n itself, and each counter steps one cycle after its event. Each stall cycle adds one cycle to every later due time. The scoreboard files each expectation under its absolute due cycle and compares it only at mid-cycle of that cycle. This keeps the checks clear of both the edge and the bench's own input changes.

// File: rtl/sfb_annul_ctl.sv
module sfb_annul_ctl #(
  parameter int NST    = 8,
  parameter int COMMIT = 8,
  parameter int CW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall_i,
  input  logic          dec_valid_i,
  input  logic          dec_branch_i,
  input  logic          dec_short_i,
  input  logic          dec_strong_i,
  input  logic          dec_pred_i,
  input  logic          res_taken_i,
  output logic          bo_take_o,
  output logic [NST-1:0] annul_o,
  output logic          flush_o,
  output logic          redir_tgt_o,
  output logic [CW-1:0] cnt_bo_o,
  output logic [CW-1:0] cnt_ann_o,
  output logic [CW-1:0] cnt_flush_o
);
  localparam int L = NST - 1;

  function automatic logic [NST-1:0] f_ok();
    logic [NST-1:0] m;
    for (int i = 0; i < NST; i++) m[i] = (i + 1 < COMMIT);
    return m;
  endfunction
  localparam logic [NST-1:0] OK_MASK = f_ok();

  logic [NST-1:0] v, br, pt, bo, sh, an;
  logic bo_act, need_sh;

  wire adv     = ~stall_i;
  wire res_v   = adv & v[L] & br[L] & ~an[L];
  wire res_bo  = res_v & bo[L];
  wire res_ord = res_v & ~bo[L];

  wire [NST-1:0] shv = v & sh & ~an;
  wire sh_ok    = |(shv & OK_MASK);
  wire bo_annul = res_bo & res_taken_i & sh_ok;
  wire [NST-1:0] mark = bo_annul ? (shv & OK_MASK) : '0;

  assign flush_o     = (res_ord & (res_taken_i ^ pt[L])) | (res_bo & res_taken_i & ~sh_ok);
  assign redir_tgt_o = res_taken_i;

  wire busy = bo_act & ~res_bo;
  assign bo_take_o = adv & ~flush_o & dec_valid_i & dec_branch_i & dec_short_i
                   & ~dec_strong_i & ~busy;

  wire enter   = adv & ~flush_o & dec_valid_i;
  wire take_sh = enter & need_sh & ~res_bo;

  wire [NST-1:0] anm = an | mark;
  wire [NST-1:0] shm = res_bo ? '0 : sh;

  assign annul_o = v & an;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v <= '0; br <= '0; pt <= '0; bo <= '0; sh <= '0; an <= '0;
      bo_act <= 1'b0; need_sh <= 1'b0;
    end else if (adv) begin
      if (flush_o) begin
        v <= '0; sh <= '0;
        bo_act <= 1'b0; need_sh <= 1'b0;
      end else begin
        v  <= {v[NST-2:0], dec_valid_i};
        br <= {br[NST-2:0], dec_valid_i & dec_branch_i};
        pt <= {pt[NST-2:0], dec_pred_i & ~bo_take_o};
        bo <= {bo[NST-2:0], bo_take_o};
        an <= {anm[NST-2:0], 1'b0};
        sh <= {shm[NST-2:0], take_sh};
        bo_act  <= bo_take_o | (bo_act & ~res_bo);
        need_sh <= bo_take_o | (need_sh & ~take_sh & ~res_bo);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_bo_o <= '0; cnt_ann_o <= '0; cnt_flush_o <= '0;
    end else begin
      if (bo_take_o) cnt_bo_o    <= cnt_bo_o + 1'b1;
      if (bo_annul)  cnt_ann_o   <= cnt_ann_o + 1'b1;
      if (flush_o)   cnt_flush_o <= cnt_flush_o + 1'b1;
    end
  end
endmodule

module sfb_annul_chk #(
  parameter int NST = 8,
  parameter int CW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           stall_i,
  input logic           flush_o,
  input logic           bo_take_o,
  input logic [NST-1:0] annul_o,
  input logic [NST-1:0] slot_v,
  input logic [NST-1:0] slot_bo,
  input logic [CW-1:0]  cnt_flush
);
  p_one_inflight_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_v & slot_bo) <= 1);
  p_single_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(annul_o) <= 1);
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> (slot_v == '0));
  p_flush_counted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> (cnt_flush == CW'($past(cnt_flush) + 1'b1)));
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> ($stable(annul_o) && $stable(slot_v)));
  p_no_accept_in_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> !bo_take_o);
endmodule

bind sfb_annul_ctl sfb_annul_chk #(.NST(NST), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .flush_o(flush_o),
  .bo_take_o(bo_take_o), .annul_o(annul_o), .slot_v(v), .slot_bo(bo),
  .cnt_flush(cnt_flush_o)
);

// File: tb/sim_sfb_annul_ctl.sv
module sim_sfb_annul_ctl;
  localparam int NST = 8;
  localparam int CW  = 16;
  localparam int F_TAKE = 0, F_FLUSH = 1, F_TGT = 2, F_ANNUL = 3,
                 F_CBO = 4, F_CANN = 5, F_CFL = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall_i = 1'b0, dec_valid_i = 1'b0, dec_branch_i = 1'b0, dec_short_i = 1'b0;
  logic dec_strong_i = 1'b0, dec_pred_i = 1'b0, res_taken_i = 1'b0;
  logic bo_take_o, flush_o, redir_tgt_o;
  logic [NST-1:0] annul_o;
  logic [CW-1:0] cnt_bo_o, cnt_ann_o, cnt_flush_o;

  always #2 clk = ~clk;

  sfb_annul_ctl #(.NST(NST), .COMMIT(8), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .dec_valid_i(dec_valid_i),
    .dec_branch_i(dec_branch_i), .dec_short_i(dec_short_i), .dec_strong_i(dec_strong_i),
    .dec_pred_i(dec_pred_i), .res_taken_i(res_taken_i), .bo_take_o(bo_take_o),
    .annul_o(annul_o), .flush_o(flush_o), .redir_tgt_o(redir_tgt_o),
    .cnt_bo_o(cnt_bo_o), .cnt_ann_o(cnt_ann_o), .cnt_flush_o(cnt_flush_o));

  typedef struct { int cyc; int fld; int val; string req; } exp_t;
  exp_t q[$];
  int cyc_n = 0, base = 0, checks = 0, fails = 0;
  int e_bo = 0, e_ann = 0, e_fl = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc_n <= cyc_n + 1;

  function automatic int field(int f);
    case (f)
      F_TAKE:  return int'(bo_take_o);
      F_FLUSH: return int'(flush_o);
      F_TGT:   return int'(redir_tgt_o);
      F_ANNUL: return int'(annul_o);
      F_CBO:   return int'(cnt_bo_o);
      F_CANN:  return int'(cnt_ann_o);
      default: return int'(cnt_flush_o);
    endcase
  endfunction

  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc_n) begin
        int got;
        got = field(q[i].fld);
        checks++;
        if (got != q[i].val) begin
          fails++;
          $display("FAIL %s cycle %0d field %0d actual=%0h expected=%0h",
                   q[i].req, cyc_n, q[i].fld, got, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic expect_at(int off, int fld, int val, string req);
    exp_t e;
    e.cyc = base + off; e.fld = fld; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  task automatic step(bit dv, bit db, bit ds, bit dst, bit dp, bit rt, bit st);
    dec_valid_i = dv; dec_branch_i = db; dec_short_i = ds;
    dec_strong_i = dst; dec_pred_i = dp; res_taken_i = rt; stall_i = st;
    @(posedge clk); #1;
  endtask

  task automatic nop(bit rt = 1'b0);  step(1, 0, 0, 0, 0, rt, 0); endtask
  task automatic idle(bit rt = 1'b0); step(0, 0, 0, 0, 0, rt, 0); endtask
  task automatic bov();               step(1, 1, 1, 0, 0, 0, 0); endtask
  task automatic ordb(bit p);         step(1, 1, 0, 0, p, 0, 0); endtask

  task automatic drain_and_count(string req);
    repeat (10) idle();
    base = cyc_n;
    expect_at(0, F_CBO, e_bo, req);
    expect_at(0, F_CANN, e_ann, req);
    expect_at(0, F_CFL, e_fl, req);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    base = cyc_n;
    expect_at(0, F_ANNUL, 0, "R1"); expect_at(0, F_FLUSH, 0, "R1");
    expect_at(0, F_CBO, 0, "R1"); expect_at(0, F_CANN, 0, "R1"); expect_at(0, F_CFL, 0, "R1");
    idle();

    // R2 / R5: branch-over taken, shadow annulled, no flush
    base = cyc_n;
    expect_at(0, F_TAKE, 1, "R2");
    expect_at(1, F_CBO, e_bo + 1, "R2");
    expect_at(8, F_FLUSH, 0, "R5");
    expect_at(9, F_ANNUL, 'h80, "R5");
    bov(); repeat (7) nop(); nop(1); nop();
    e_bo++; e_ann++;
    drain_and_count("R5");

    // R6: not taken, release same cycle lets a new branch-over in
    base = cyc_n;
    expect_at(8, F_TAKE, 1, "R6"); expect_at(8, F_FLUSH, 0, "R6");
    expect_at(9, F_ANNUL, 0, "R6");
    bov(); repeat (7) nop();
    step(1, 1, 1, 0, 0, 0, 0);
    repeat (7) nop(); nop(0);
    e_bo += 2;
    drain_and_count("R6");

    // R3: second eligible while one in flight is ordinary
    base = cyc_n;
    expect_at(1, F_TAKE, 0, "R3");
    expect_at(8, F_FLUSH, 0, "R3");
    expect_at(9, F_FLUSH, 1, "R3"); expect_at(9, F_TGT, 1, "R3");
    bov(); step(1, 1, 1, 0, 0, 0, 0); repeat (6) nop(); nop(0); nop(1);
    e_bo++; e_fl++;
    drain_and_count("R3");

    // R4: strongly taken uses ordinary prediction
    base = cyc_n;
    expect_at(0, F_TAKE, 0, "R4");
    expect_at(8, F_FLUSH, 0, "R4"); expect_at(9, F_ANNUL, 0, "R4");
    step(1, 1, 1, 1, 1, 0, 0); repeat (7) nop(); nop(1); nop();
    drain_and_count("R4");

    // R7: ordinary mispredicts, both directions
    base = cyc_n;
    expect_at(8, F_FLUSH, 1, "R7"); expect_at(8, F_TGT, 1, "R7");
    expect_at(9, F_CFL, e_fl + 1, "R7");
    ordb(0); repeat (7) nop(); nop(1); nop();
    e_fl++;
    base = cyc_n;
    expect_at(8, F_FLUSH, 1, "R7"); expect_at(8, F_TGT, 0, "R7");
    expect_at(9, F_ANNUL, 0, "R7");
    ordb(1); repeat (7) nop(); nop(0); nop();
    e_fl++;
    drain_and_count("R7");

    // R8: shadow not yet fetched when taken
    base = cyc_n;
    expect_at(8, F_FLUSH, 1, "R8"); expect_at(8, F_TGT, 1, "R8");
    bov(); repeat (7) idle(); idle(1);
    e_bo++; e_fl++;
    drain_and_count("R8");

    // R9: stall holds resolve and annul state
    base = cyc_n;
    expect_at(8, F_FLUSH, 0, "R9"); expect_at(9, F_ANNUL, 0, "R9");
    expect_at(10, F_CANN, e_ann, "R9"); expect_at(11, F_ANNUL, 0, "R9");
    expect_at(12, F_ANNUL, 'h80, "R9");
    bov(); repeat (7) nop();
    repeat (3) step(0, 0, 0, 0, 0, 1, 1);
    nop(1); nop();
    e_bo++; e_ann++;
    drain_and_count("R9");

    // R10: older flush discards pending branch-over
    base = cyc_n;
    expect_at(1, F_TAKE, 1, "R10");
    expect_at(8, F_FLUSH, 1, "R10");
    expect_at(9, F_TAKE, 1, "R10");
    ordb(0); bov(); repeat (6) nop(); nop(1);
    bov(); repeat (7) nop(); nop(0);
    e_bo += 2; e_fl++;
    drain_and_count("R10");

    // R11: annulled branch in shadow is not resolved
    base = cyc_n;
    expect_at(9, F_ANNUL, 'h80, "R11"); expect_at(9, F_FLUSH, 0, "R11");
    bov(); ordb(0); repeat (6) nop(); nop(1); nop(1);
    e_bo++; e_ann++;
    drain_and_count("R11");

    repeat (2) idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule